// File: doc/BRIEF.md
# Quad Wiper Register Controller with Serial Two-Wire Access

This block is a two-wire serial (I2C) slave that owns four 8-bit wiper registers. Each wiper has four 8-bit storage slots, modelled as a behavioural non-volatile array, so there are 16 stored bytes in all. The block samples SCL and SDA on its system clock and drives SDA through an open-drain enable. A transfer has three bytes: an address byte, an instruction byte, and one data byte that is either written or read.

The address byte is always eight bits: the fixed pattern 0101 in bits 7:4, followed by the four strap pins in bits 3:0. The direction of the transfer comes from the instruction opcode, not from the address byte. The instruction chooses one of four operations: read a wiper, write a wiper, read a storage slot, or write a storage slot.

Writing a wiper changes its output straight away. Writing a storage slot starts a programming window when the next stop arrives. During that window the busy output is high and the block does not acknowledge its address. When reset is released, slot 0 of each potentiometer is copied into that potentiometer's wiper. The four wiper values drive the tap selection of an external resistor ladder, one value per potentiometer.

Top module: `wpot_ctrl_top`

## Requirements
- R1: The block acknowledges an address byte only when the byte equals {4'b0101, addrStrap}. After any other address byte it leaves SDA released for the rest of the transfer, including the acknowledge slot of every following byte.
- R2: The instruction byte has three fields. Bits 7:4 are the opcode: 1001 reads a wiper, 1010 writes a wiper, 1011 reads a storage slot, and 1100 writes a storage slot. Bits 3:2 are the slot number and bits 1:0 are the potentiometer number. A byte written to a slot is returned by a later read of the same slot.
- R3: The block does not acknowledge an instruction byte whose opcode is not one of the four listed in R2. It also does not acknowledge a wiper opcode whose slot field is nonzero. In both cases it acknowledges nothing more until the next start, and no register changes.
- R4: The block acknowledges the data byte of a wiper write. The selected wiper output takes the new value while the acknowledge is being driven. All other wipers keep their values, and busy stays low.
- R5: After a read instruction is acknowledged, the block shifts out the selected byte MSB first, one bit per SCL clock. It then releases SDA for the master's acknowledge slot and for the rest of the transfer.
- R6: A stop that follows an acknowledged storage write raises busy. Busy stays high for PROG_CYCLES clock cycles and then falls.
- R7: While busy is high, the block does not acknowledge its own address.
- R8: Within two clock cycles after reset is released, every wiper output equals slot 0 of its own potentiometer. The storage array keeps its contents across reset.
- R9: A repeated start in the middle of a transfer drops the partly decoded instruction. The next byte is then decoded as a new address byte.
- R10: The wiperOut bus carries potentiometer p in bits 8p+7:8p.
- R11: A fall of SDA while SCL is low does not count as a start. The block changes sdaOutEn only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock. SCL and SDA are sampled on this clock. |
| rstN | input | 1 | Asynchronous active-low reset. Releasing it triggers the recall of slot 0. |
| sclIn | input | 1 | Serial clock level seen on the bus. |
| sdaIn | input | 1 | Serial data level seen on the bus. |
| sdaOutEn | output | 1 | When 1, the bus pad pulls SDA low. |
| addrStrap | input | 4 | Strap pins that form the low nibble of the address byte. |
| wiperOut | output | 32 | The four 8-bit wiper values, packed as described in R10. |
| busy | output | 1 | High while a storage programming window is running. |

## Verification
A corrupted bit counter or a wrong state register shows up as a missing or misplaced acknowledge in the very next ninth-bit slot. It can also show up as a read byte that is shifted by one position, which the bench sees within one byte time. The bench compares the wiper bus with its reference model on every clock, so a wiper that is written wrongly, or changed when it should not be, is caught in the cycle after it moves. A wrong storage slot or a lost recall only becomes visible after a later read or after the next reset. For that reason, every storage write is followed by a read-back or by a reset with a full comparison of the wipers.

// File: rtl/wpot_pkg.sv
package wpot_pkg;
  localparam int POT_SEL_W  = 2;
  localparam int SLOT_SEL_W = 2;
  localparam int NUM_POTS   = 1 << POT_SEL_W;
  localparam int NUM_SLOTS  = 1 << SLOT_SEL_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_INSTR, ST_WDATA, ST_RDATA, ST_ACK, ST_IGNORE
  } busState_t;

  localparam logic [3:0] OP_RD_WIPER = 4'b1001;
  localparam logic [3:0] OP_WR_WIPER = 4'b1010;
  localparam logic [3:0] OP_RD_STORE = 4'b1011;
  localparam logic [3:0] OP_WR_STORE = 4'b1100;

  typedef struct packed {
    logic                  shiftIn;
    logic                  shiftOut;
    logic                  loadRead;
    logic                  srcStore;
    logic                  writeWiper;
    logic                  writeStore;
    logic                  startProg;
    logic [SLOT_SEL_W-1:0] slot;
    logic [POT_SEL_W-1:0]  pot;
  } dpCtrl_t;
endpackage

// File: rtl/wpot_bus_sync.sv
module wpot_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  logic [STAGES-1:0] sclPipe, sdaPipe;
  logic sclLast, sdaLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclLast <= 1'b1;
      sdaLast <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
      sclLast <= sclPipe[STAGES-1];
      sdaLast <= sdaPipe[STAGES-1];
    end
  end

  assign sclS     = sclPipe[STAGES-1];
  assign sdaS     = sdaPipe[STAGES-1];
  assign sclRise  = sclS & ~sclLast;
  assign sclFall  = ~sclS & sclLast;
  assign startDet = sclS & sclLast & sdaLast & ~sdaS;
  assign stopDet  = sclS & sclLast & ~sdaLast & sdaS;
endmodule

// File: rtl/wpot_control.sv
module wpot_control
  import wpot_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclS,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  input  logic       busy,
  input  logic [3:0] addrStrap,
  output dpCtrl_t    ctl,
  output logic       sdaOutEn
);
  busState_t state, ackNext;
  logic [3:0] bitCnt;
  logic ackDrive, isStore, armProg;
  logic [SLOT_SEL_W-1:0] slotQ;
  logic [POT_SEL_W-1:0] potQ;

  logic [3:0] opField;
  logic instrOk, instrRead, addrOk, byteEnd;

  assign opField   = rxByte[7:4];
  assign instrOk   = ((opField == OP_RD_WIPER || opField == OP_WR_WIPER) && rxByte[3:2] == 2'b00)
                   || opField == OP_RD_STORE || opField == OP_WR_STORE;
  assign instrRead = (opField == OP_RD_WIPER) || (opField == OP_RD_STORE);
  assign addrOk    = (rxByte == {4'b0101, addrStrap}) && !busy;
  assign byteEnd   = sclFall && (bitCnt == 4'd8);

  always_comb begin
    ctl            = '0;
    ctl.slot       = slotQ;
    ctl.pot        = potQ;
    ctl.srcStore   = isStore;
    ctl.shiftIn    = sclRise && (state == ST_ADDR || state == ST_INSTR || state == ST_WDATA);
    ctl.shiftOut   = sclFall && state == ST_RDATA && bitCnt != 4'd8;
    ctl.loadRead   = sclFall && state == ST_ACK && ackNext == ST_RDATA;
    ctl.writeWiper = byteEnd && state == ST_WDATA && !isStore;
    ctl.writeStore = byteEnd && state == ST_WDATA && isStore;
    ctl.startProg  = stopDet && armProg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      ackNext  <= ST_IDLE;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
      isStore  <= 1'b0;
      armProg  <= 1'b0;
      slotQ    <= '0;
      potQ     <= '0;
    end else if (startDet) begin
      state    <= ST_ADDR;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
    end else if (stopDet) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
      armProg  <= 1'b0;
    end else begin
      if (sclRise && (state == ST_ADDR || state == ST_INSTR ||
                      state == ST_WDATA || state == ST_RDATA))
        bitCnt <= bitCnt + 4'd1;
      if (sclFall) begin
        case (state)
          ST_ADDR: if (bitCnt == 4'd8) begin
            bitCnt <= '0;
            if (addrOk) begin
              ackDrive <= 1'b1;
              state    <= ST_ACK;
              ackNext  <= ST_INSTR;
            end else state <= ST_IGNORE;
          end
          ST_INSTR: if (bitCnt == 4'd8) begin
            bitCnt <= '0;
            if (instrOk) begin
              ackDrive <= 1'b1;
              state    <= ST_ACK;
              ackNext  <= instrRead ? ST_RDATA : ST_WDATA;
              isStore  <= (opField == OP_RD_STORE) || (opField == OP_WR_STORE);
              slotQ    <= rxByte[3:2];
              potQ     <= rxByte[1:0];
            end else state <= ST_IGNORE;
          end
          ST_WDATA: if (bitCnt == 4'd8) begin
            bitCnt   <= '0;
            ackDrive <= 1'b1;
            state    <= ST_ACK;
            ackNext  <= ST_IGNORE;
            if (isStore) armProg <= 1'b1;
          end
          ST_RDATA: if (bitCnt == 4'd8) begin
            bitCnt <= '0;
            state  <= ST_IGNORE;
          end
          ST_ACK: begin
            ackDrive <= 1'b0;
            state    <= ackNext;
          end
          default: ;
        endcase
      end
    end
  end

  assign sdaOutEn = ackDrive | (state == ST_RDATA && !txBit);

  // R7: an address byte that ends while busy is high must not be acknowledged
  p_nack_when_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR && byteEnd && busy) |=> !sdaOutEn);

  // R11: SDA drive changes only while SCL is low
  p_sda_stable_high_r11: assert property (@(posedge clk) disable iff (!rstN)
    (sclS && $past(sclS)) |-> $stable(sdaOutEn));

  // R3: once the bus is being ignored, SDA stays released
  p_ignore_released_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IGNORE) |-> !sdaOutEn);
endmodule

// File: rtl/wpot_datapath.sv
module wpot_datapath
  import wpot_pkg::*;
#(
  parameter int         PROG_CYCLES = 250000,
  parameter logic [7:0] STORE_INIT  = 8'h80
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sdaS,
  input  dpCtrl_t               ctl,
  output logic [7:0]            rxByte,
  output logic                  txBit,
  output logic                  busy,
  output logic [NUM_POTS*8-1:0] wiperOut
);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);

  logic [7:0] shreg;
  logic [7:0] wiperQ [NUM_POTS];
  logic [7:0] store  [NUM_POTS][NUM_SLOTS];
  logic [CNT_W-1:0] progCnt;
  logic recallPend;

  initial begin
    for (int p = 0; p < NUM_POTS; p++)
      for (int s = 0; s < NUM_SLOTS; s++)
        store[p][s] = STORE_INIT;
  end

  always_ff @(posedge clk) begin
    if (ctl.writeStore) store[ctl.pot][ctl.slot] <= shreg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) recallPend <= 1'b1;
    else       recallPend <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             shreg <= '0;
    else if (ctl.shiftIn)  shreg <= {shreg[6:0], sdaS};
    else if (ctl.loadRead) shreg <= ctl.srcStore ? store[ctl.pot][ctl.slot] : wiperQ[ctl.pot];
    else if (ctl.shiftOut) shreg <= {shreg[6:0], 1'b0};
  end

  for (genvar p = 0; p < NUM_POTS; p++) begin : g_pot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                               wiperQ[p] <= '0;
      else if (recallPend)                                     wiperQ[p] <= store[p][0];
      else if (ctl.writeWiper && ctl.pot == POT_SEL_W'(p))     wiperQ[p] <= shreg;
    end
    assign wiperOut[p*8 +: 8] = wiperQ[p];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 progCnt <= '0;
    else if (ctl.startProg)    progCnt <= CNT_W'(PROG_CYCLES);
    else if (progCnt != '0)    progCnt <= progCnt - 1'b1;
  end

  assign busy   = (progCnt != '0);
  assign rxByte = shreg;
  assign txBit  = shreg[7];

  // R6: a stop after a storage write opens the busy window
  p_prog_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.startProg |=> busy);

  // R4: wipers move only on a wiper write or the reset recall
  p_wiper_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.writeWiper && !recallPend) |=> $stable(wiperOut));
endmodule

// File: rtl/wpot_ctrl_top.sv
module wpot_ctrl_top
  import wpot_pkg::*;
#(
  parameter int         PROG_CYCLES = 250000,
  parameter logic [7:0] STORE_INIT  = 8'h80,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaOutEn,
  input  logic [3:0]            addrStrap,
  output logic [NUM_POTS*8-1:0] wiperOut,
  output logic                  busy
);
  logic sclS, sdaS, sclRise, sclFall, startDet, stopDet, txBit;
  logic [7:0] rxByte;
  dpCtrl_t ctl;

  wpot_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  wpot_control u_ctrl (
    .clk(clk), .rstN(rstN), .sclS(sclS), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .rxByte(rxByte), .txBit(txBit),
    .busy(busy), .addrStrap(addrStrap), .ctl(ctl), .sdaOutEn(sdaOutEn)
  );

  wpot_datapath #(.PROG_CYCLES(PROG_CYCLES), .STORE_INIT(STORE_INIT)) u_dp (
    .clk(clk), .rstN(rstN), .sdaS(sdaS), .ctl(ctl), .rxByte(rxByte),
    .txBit(txBit), .busy(busy), .wiperOut(wiperOut)
  );
endmodule

// File: tb/sim_wpot_ctrl_top.sv
`timescale 1ns/1ps
module sim_wpot_ctrl_top;
  localparam int         PROG = 400;
  localparam int         Q    = 8;
  localparam logic [7:0] INIT = 8'h80;
  localparam logic [3:0] STRAP = 4'hA;
  localparam logic [7:0] ADDR = {4'b0101, STRAP};

  logic clk = 0, rstN = 0, mScl = 1, mSda = 1;
  logic sdaOutEn, busy, sdaLine;
  logic [31:0] wiperOut;
  int checks = 0, fails = 0;
  bit monEn = 0;
  int mWiper [4];
  int mStore [4][4];

  always #4 clk = ~clk;
  assign sdaLine = mSda & ~sdaOutEn;

  wpot_ctrl_top #(.PROG_CYCLES(PROG), .STORE_INIT(INIT)) u0 (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine), .sdaOutEn(sdaOutEn),
    .addrStrap(STRAP), .wiperOut(wiperOut), .busy(busy)
  );

  function automatic logic [31:0] expW();
    return {mWiper[3][7:0], mWiper[2][7:0], mWiper[1][7:0], mWiper[0][7:0]};
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (monEn) check(wiperOut == expW(), "R10 wiper model", wiperOut, expW());

  task automatic tick(int n); repeat (n) @(negedge clk); endtask
  task automatic busStart(); mSda = 1; tick(Q); mScl = 1; tick(Q); mSda = 0; tick(Q); mScl = 0; tick(Q); endtask
  task automatic busStop(); mSda = 0; tick(Q); mScl = 1; tick(Q); mSda = 1; tick(Q); endtask
  task automatic sendBit(bit b); mSda = b; tick(Q); mScl = 1; tick(2*Q); mScl = 0; tick(Q); endtask
  task automatic getBit(output bit b);
    mSda = 1; tick(Q); mScl = 1; tick(Q); b = sdaLine; tick(Q); mScl = 0; tick(Q);
  endtask
  task automatic sendByte(logic [7:0] d, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    getBit(b);
    ack = !b;
  endtask
  task automatic recvByte(output logic [7:0] d);
    bit b;
    for (int i = 7; i >= 0; i--) begin getBit(b); d[i] = b; end
    sendBit(1'b1);
  endtask
  task automatic xferWrite(logic [7:0] a, logic [7:0] ins, logic [7:0] d, output bit k0, k1, k2);
    busStart(); sendByte(a, k0); sendByte(ins, k1); sendByte(d, k2); busStop();
  endtask
  task automatic xferRead(logic [7:0] ins, output bit k0, k1, output logic [7:0] d, output bit rel);
    busStart(); sendByte(ADDR, k0); sendByte(ins, k1); recvByte(d);
    tick(2); rel = sdaLine; busStop();
  endtask
  task automatic waitIdle();
    int n = 0;
    while (busy && n < 4 * PROG) begin tick(1); n++; end
    check(!busy, "R6 busy falls", {31'd0, busy}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit k0, k1, k2, rel;
    logic [7:0] d;
    for (int p = 0; p < 4; p++) begin
      mWiper[p] = INIT;
      for (int s = 0; s < 4; s++) mStore[p][s] = INIT;
    end
    tick(10); rstN = 1; tick(5);
    check(wiperOut == expW(), "R8 reset recall", wiperOut, expW());
    check(!busy, "R6 idle after reset", {31'd0, busy}, 32'd0);
    check(!sdaOutEn, "R1 released at reset", {31'd0, sdaOutEn}, 32'd0);
    monEn = 1;

    // R4 / R10: wiper write to potentiometer 2
    monEn = 0;
    xferWrite(ADDR, 8'hA2, 8'h3C, k0, k1, k2);
    check(k0 && k1 && k2, "R4 write acks", {29'd0, k0, k1, k2}, 32'd7);
    mWiper[2] = 8'h3C;
    check(wiperOut == expW(), "R10 wiper lane", wiperOut, expW());
    tick(10);
    check(!busy, "R4 no busy", {31'd0, busy}, 32'd0);
    monEn = 1;

    // R5: read back wiper 2
    xferRead(8'h92, k0, k1, d, rel);
    check(k0 && k1, "R5 read acks", {30'd0, k0, k1}, 32'd3);
    check(d == 8'h3C, "R5 read data", {24'd0, d}, 32'h3C);
    check(rel, "R5 released after byte", {31'd0, rel}, 32'd1);

    // R1: wrong address
    xferWrite(8'h5B, 8'hA0, 8'h00, k0, k1, k2);
    check(!k0, "R1 wrong address nack", {31'd0, k0}, 32'd0);
    check(!k1 && !k2, "R1 later bytes nack", {30'd0, k1, k2}, 32'd0);

    // R3: undefined opcode and nonzero slot on wiper opcode
    xferWrite(ADDR, 8'hF1, 8'h12, k0, k1, k2);
    check(k0 && !k1, "R3 bad opcode nack", {30'd0, k0, k1}, 32'd2);
    check(!k2, "R3 data ignored", {31'd0, k2}, 32'd0);
    xferWrite(ADDR, 8'hA6, 8'h55, k0, k1, k2);
    check(!k1 && !k2, "R3 wiper slot nonzero", {30'd0, k1, k2}, 32'd0);
    check(wiperOut == expW(), "R3 wipers unchanged", wiperOut, expW());

    // R2 / R6 / R7: storage write to pot 1 slot 3
    xferWrite(ADDR, 8'hCD, 8'hA5, k0, k1, k2);
    check(k0 && k1 && k2, "R2 store write acks", {29'd0, k0, k1, k2}, 32'd7);
    mStore[1][3] = 8'hA5;
    tick(10);
    check(busy, "R6 busy after stop", {31'd0, busy}, 32'd1);
    busStart(); sendByte(ADDR, k0); busStop();
    check(!k0, "R7 nack while busy", {31'd0, k0}, 32'd0);
    waitIdle();
    xferRead(8'hBD, k0, k1, d, rel);
    check(d == 8'hA5, "R2 store read back", {24'd0, d}, 32'hA5);

    // R9: repeated start discards a half-done wiper write
    busStart(); sendByte(ADDR, k0); sendByte(8'hA0, k1);
    busStart(); sendByte(ADDR, k2); sendByte(8'h90, rel);
    recvByte(d); busStop();
    check(k0 && k1 && k2 && rel, "R9 acks", {28'd0, k0, k1, k2, rel}, 32'hF);
    check(d == 8'h80, "R9 wiper 0 untouched", {24'd0, d}, 32'h80);

    // R11: SDA edges while SCL is low are not a start
    mScl = 0; tick(Q); mSda = 0; tick(Q); mSda = 1; tick(Q);
    sendByte(ADDR, k0);
    check(!k0, "R11 no start, no ack", {31'd0, k0}, 32'd0);
    busStop();

    // R8: slot 0 recall on reset
    xferWrite(ADDR, 8'hC0, 8'h11, k0, k1, k2); mStore[0][0] = 8'h11; waitIdle();
    xferWrite(ADDR, 8'hC3, 8'h77, k0, k1, k2); mStore[3][0] = 8'h77; waitIdle();
    monEn = 0;
    xferWrite(ADDR, 8'hA1, 8'h22, k0, k1, k2); mWiper[1] = 8'h22;
    check(wiperOut == expW(), "R4 wiper 1 write", wiperOut, expW());
    rstN = 0; tick(4); rstN = 1; tick(3);
    for (int p = 0; p < 4; p++) mWiper[p] = mStore[p][0];
    check(wiperOut == expW(), "R8 recall after reset", wiperOut, expW());
    monEn = 1;
    xferRead(8'hB3, k0, k1, d, rel);
    check(d == 8'h77, "R8 storage kept over reset", {24'd0, d}, 32'h77);

    tick(20);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule